// File: doc/BRIEF.md
# Four-Channel Bus-Mastering DMA Controller

This block moves single bytes between peripheral interfaces and memory so that the CPU does not have to copy them itself. Each of four channels keeps a 16-bit current address, a 16-bit remaining byte count, a mask bit, a direction and a release policy. When an unmasked channel with bytes left raises its request, the controller asks the CPU for the bus through a hold request. It waits for the hold acknowledge and then runs one bus cycle per byte. In each cycle it drives the address, asserts the channel's acknowledge, and pulses the paired memory and I/O strobes.

Software programs the channels through a byte-wide register port with a 4-bit register address. A first/last toggle chooses whether an access to a 16-bit channel register reaches its low or its high byte. In single mode the bus is given back after every byte and the channels compete again. In burst mode the controller keeps the bus until the channel's count reaches zero. An external latch can capture the upper address byte on a separate strobe. That strobe fires after each new grant, and during a burst only when the low address byte has carried into the upper one.

Top module: `dma4_ctrl`

## Requirements
- R1: While reset is low and right after it is released: hold request low, address enable low, all four strobes high, acknowledges at their inactive level (high), end-of-process low, bus address zero, status zero. All four mask bits are set, so a raised request does not raise the hold request.
- R2: The hold request rises when a channel is unmasked, has a nonzero count and has an active request (hardware or software). Address enable, acknowledges and strobes stay inactive until the hold acknowledge has been seen high.
- R3: Each byte takes one address cycle (address enable high, address driven, no strobe) and then one or more strobe cycles in which the channel's acknowledge is active. After the byte the channel's address rises by 1 and its count falls by 1.
- R4: Mode bit 2 = 0 (write) pulses I/O read and memory write together. Mode bit 2 = 1 (read) pulses memory read and I/O write together.
- R5: In burst mode (mode bit 3 = 1) the hold request stays high from the grant until the count reaches zero. In single mode (bit 3 = 0) it drops after every byte, and the channels are arbitrated again.
- R6: Priority is fixed: the lowest-numbered eligible channel wins. The choice is made at each grant.
- R7: A low ready input holds the strobe cycle: the strobes, the acknowledge and the address stay put and no update happens until ready is high.
- R8: The upper-address strobe pulses in the address cycle after every grant. Within a burst it pulses again only in the address cycle after a byte whose low address byte was 0xFF.
- R9: When a channel's count reaches zero, its terminal-count status bit and its mask bit are set, its software request is cleared, and end-of-process is high for exactly one cycle.
- R10: Command bit 0 = 1 makes the request inputs active low. Command bit 1 = 1 makes the acknowledges active high. Both are 0 after reset.
- R11: Register map: address 2n / 2n+1 are channel n's address / count. Each access to them moves a byte (low byte when the toggle is 0) and flips the toggle. Address 8 is the command. Address 9 reads status: bits 3:0 terminal count, bits 7:4 active requests. Address 10 sets (bit 2 = 1) or clears one mask (bits 1:0 select the channel). Address 11 sets a mode: bits 1:0 channel, bit 2 direction, bit 3 burst. A write to 12 clears the toggle. Address 14 sets (bit 2 = 1) or clears a software request (bits 1:0 select the channel). Address 15 writes all masks from bits 3:0.
- R12: Reading status clears every terminal-count bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cpuWr | input | 1 | Register write strobe |
| cpuRd | input | 1 | Register read strobe (moves toggle, clears status) |
| cpuAddr | input | 4 | Register address |
| cpuWrData | input | 8 | Register write data |
| cpuRdData | output | 8 | Register read data for cpuAddr |
| dmaReq | input | 4 | Per-channel transfer requests, programmable polarity |
| dmaAck | output | 4 | Per-channel acknowledges, programmable polarity |
| holdReq | output | 1 | Bus request to the CPU |
| holdAck | input | 1 | Bus grant from the CPU |
| busReady | input | 1 | Low inserts wait states |
| addrEnable | output | 1 | High while the controller owns the bus |
| addrStrobe | output | 1 | Latch pulse for the upper address byte |
| busAddr | output | 16 | Transfer address, zero while not owning the bus |
| memRdN | output | 1 | Memory read strobe, active low |
| memWrN | output | 1 | Memory write strobe, active low |
| ioRdN | output | 1 | I/O read strobe, active low |
| ioWrN | output | 1 | I/O write strobe, active low |
| endOfProc | output | 1 | One-cycle pulse at terminal count |

## Verification
The bench starts a burst two bytes below a 256-byte boundary. A controller that strobed the upper byte on every byte, or never after the grant, gives the wrong pulse count. Two channels request in the same cycle in single mode, and the expected order catches inverted priority or a channel that keeps the bus between bytes. A wait held over several cycles catches a design that updates or moves the address early. A request raised before software unmasks the channel, and a grant held back, expose a controller that ignores its reset masks or drives the bus before the acknowledge. After the polarity flip both the request sense and the acknowledge level must invert, and the status read must clear only the terminal-count bits.

// File: rtl/dma_pkg.sv
`timescale 1ns/1ps
package dma_pkg;
  localparam int ChanW = 2;
  localparam int NumCh = 1 << ChanW;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HOLD, ST_ADDR, ST_XFER, ST_REL
  } dmaStateT;

  // strobes from control to datapath
  typedef struct packed {
    logic             step;    // byte done: addr+1, count-1
    logic             finish;  // count hit zero
    logic [ChanW-1:0] chan;    // channel owning the bus
  } dpCmdT;
endpackage

// File: rtl/dma_dp.sv
`timescale 1ns/1ps
module dma_dp
  import dma_pkg::*;
#(
  parameter int DataW = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cpuWr,
  input  logic                cpuRd,
  input  logic [3:0]          cpuAddr,
  input  logic [DataW-1:0]    cpuWrData,
  output logic [DataW-1:0]    cpuRdData,
  input  logic [NumCh-1:0]    dmaReq,
  input  dpCmdT               cmd,
  output logic [NumCh-1:0]    eligible,
  output logic [2*DataW-1:0]  actAddr,
  output logic                actLast,
  output logic                actLowFull,
  output logic                actBurst,
  output logic                actDir,
  output logic                ackHigh
);
  localparam int AddrW = 2 * DataW;

  logic [AddrW-1:0] addrReg [NumCh];
  logic [AddrW-1:0] cntReg  [NumCh];
  logic [NumCh-1:0] maskReg, tcReg, swReq, dirReg, burstReg;
  logic [1:0]       cmdReg;
  logic             byteHi;
  logic [NumCh-1:0] reqActive;
  logic             isChanReg, isCount;
  logic [ChanW-1:0] regChan, dataChan;
  logic [AddrW-1:0] selWord;

  assign reqActive = dmaReq ^ {NumCh{cmdReg[0]}};
  assign isChanReg = !cpuAddr[3];
  assign isCount   = cpuAddr[0];
  assign regChan   = cpuAddr[ChanW:1];
  assign dataChan  = cpuWrData[ChanW-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NumCh; i++) begin
        addrReg[i] <= '0;
        cntReg[i]  <= '0;
      end
      maskReg  <= '1;
      tcReg    <= '0;
      swReq    <= '0;
      dirReg   <= '0;
      burstReg <= '0;
      cmdReg   <= '0;
      byteHi   <= 1'b0;
    end else begin
      if (cpuWr) begin
        if (isChanReg) begin
          byteHi <= !byteHi;
          if (isCount) begin
            if (byteHi) cntReg[regChan][AddrW-1:DataW] <= cpuWrData;
            else        cntReg[regChan][DataW-1:0]     <= cpuWrData;
          end else begin
            if (byteHi) addrReg[regChan][AddrW-1:DataW] <= cpuWrData;
            else        addrReg[regChan][DataW-1:0]     <= cpuWrData;
          end
        end else begin
          case (cpuAddr[2:0])
            3'd0: cmdReg <= cpuWrData[1:0];
            3'd2: maskReg[dataChan] <= cpuWrData[2];
            3'd3: begin
              dirReg[dataChan]   <= cpuWrData[2];
              burstReg[dataChan] <= cpuWrData[3];
            end
            3'd4: byteHi <= 1'b0;
            3'd6: swReq[dataChan] <= cpuWrData[2];
            3'd7: maskReg <= cpuWrData[NumCh-1:0];
            default: ;
          endcase
        end
      end else if (cpuRd) begin
        if (isChanReg) byteHi <= !byteHi;
        else if (cpuAddr[2:0] == 3'd1) tcReg <= '0;
      end
      // transfer updates win over a same-cycle software access
      if (cmd.step) begin
        addrReg[cmd.chan] <= addrReg[cmd.chan] + AddrW'(1);
        cntReg[cmd.chan]  <= cntReg[cmd.chan] - AddrW'(1);
      end
      if (cmd.finish) begin
        tcReg[cmd.chan]   <= 1'b1;
        maskReg[cmd.chan] <= 1'b1;
        swReq[cmd.chan]   <= 1'b0;
      end
    end
  end

  always_comb begin
    cpuRdData = '0;
    selWord   = isCount ? cntReg[regChan] : addrReg[regChan];
    if (isChanReg)
      cpuRdData = byteHi ? selWord[AddrW-1:DataW] : selWord[DataW-1:0];
    else if (cpuAddr[2:0] == 3'd1)
      cpuRdData = DataW'({reqActive, tcReg});
  end

  for (genvar g = 0; g < NumCh; g++) begin : g_elig
    assign eligible[g] = !maskReg[g] && (reqActive[g] || swReq[g]) &&
                         (cntReg[g] != '0);
  end

  assign actAddr    = addrReg[cmd.chan];
  assign actLast    = (cntReg[cmd.chan] == AddrW'(1));
  assign actLowFull = &addrReg[cmd.chan][DataW-1:0];
  assign actBurst   = burstReg[cmd.chan];
  assign actDir     = dirReg[cmd.chan];
  assign ackHigh    = cmdReg[1];
endmodule

// File: rtl/dma_ctl.sv
`timescale 1ns/1ps
module dma_ctl
  import dma_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             holdAck,
  input  logic             busReady,
  input  logic [NumCh-1:0] eligible,
  input  logic             actLast,
  input  logic             actLowFull,
  input  logic             actBurst,
  input  logic             actDir,
  output dpCmdT            cmd,
  output logic             holdReq,
  output logic             addrEnable,
  output logic             addrStrobe,
  output logic             xferOn,
  output logic             memRdOn,
  output logic             memWrOn,
  output logic             endOfProc
);
  dmaStateT         state;
  logic [ChanW-1:0] chanQ, winner;
  logic             newGrantQ, carryQ, eopQ;

  // fixed priority: lowest index wins
  always_comb begin
    winner = '0;
    for (int i = NumCh - 1; i >= 0; i--)
      if (eligible[i]) winner = ChanW'(i);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      chanQ     <= '0;
      newGrantQ <= 1'b0;
      carryQ    <= 1'b0;
      eopQ      <= 1'b0;
    end else begin
      eopQ <= 1'b0;
      case (state)
        ST_IDLE: if (|eligible) state <= ST_HOLD;
        ST_HOLD: begin
          if (holdAck) begin
            if (|eligible) begin
              chanQ     <= winner;
              newGrantQ <= 1'b1;
              state     <= ST_ADDR;
            end else begin
              state <= ST_REL;
            end
          end else if (!(|eligible)) begin
            state <= ST_IDLE;
          end
        end
        ST_ADDR: begin
          newGrantQ <= 1'b0;
          carryQ    <= 1'b0;
          state     <= ST_XFER;
        end
        ST_XFER: begin
          if (busReady) begin
            if (actLast) begin
              eopQ  <= 1'b1;
              state <= ST_REL;
            end else if (actBurst) begin
              carryQ <= actLowFull;
              state  <= ST_ADDR;
            end else begin
              state <= ST_REL;
            end
          end
        end
        ST_REL:  if (!holdAck) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign cmd.chan   = chanQ;
  assign cmd.step   = (state == ST_XFER) && busReady;
  assign cmd.finish = (state == ST_XFER) && busReady && actLast;

  assign holdReq    = (state == ST_HOLD) || (state == ST_ADDR) || (state == ST_XFER);
  assign addrEnable = (state == ST_ADDR) || (state == ST_XFER);
  assign addrStrobe = (state == ST_ADDR) && (newGrantQ || carryQ);
  assign xferOn     = (state == ST_XFER);
  assign memRdOn    = (state == ST_XFER) && actDir;
  assign memWrOn    = (state == ST_XFER) && !actDir;
  assign endOfProc  = eopQ;
endmodule

// File: rtl/dma4_ctrl.sv
`timescale 1ns/1ps
module dma4_ctrl
  import dma_pkg::*;
#(
  parameter int DataW = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cpuWr,
  input  logic                cpuRd,
  input  logic [3:0]          cpuAddr,
  input  logic [DataW-1:0]    cpuWrData,
  output logic [DataW-1:0]    cpuRdData,
  input  logic [NumCh-1:0]    dmaReq,
  output logic [NumCh-1:0]    dmaAck,
  output logic                holdReq,
  input  logic                holdAck,
  input  logic                busReady,
  output logic                addrEnable,
  output logic                addrStrobe,
  output logic [2*DataW-1:0]  busAddr,
  output logic                memRdN,
  output logic                memWrN,
  output logic                ioRdN,
  output logic                ioWrN,
  output logic                endOfProc
);
  localparam int AddrW = 2 * DataW;

  dpCmdT            cmd;
  logic [NumCh-1:0] eligible;
  logic [AddrW-1:0] actAddr;
  logic             actLast, actLowFull, actBurst, actDir, ackHigh;
  logic             xferOn, memRdOn, memWrOn;

  dma_dp #(.DataW(DataW)) u_dp (
    .clk(clk), .rstN(rstN),
    .cpuWr(cpuWr), .cpuRd(cpuRd), .cpuAddr(cpuAddr),
    .cpuWrData(cpuWrData), .cpuRdData(cpuRdData),
    .dmaReq(dmaReq), .cmd(cmd), .eligible(eligible),
    .actAddr(actAddr), .actLast(actLast), .actLowFull(actLowFull),
    .actBurst(actBurst), .actDir(actDir), .ackHigh(ackHigh)
  );

  dma_ctl u_ctl (
    .clk(clk), .rstN(rstN),
    .holdAck(holdAck), .busReady(busReady), .eligible(eligible),
    .actLast(actLast), .actLowFull(actLowFull), .actBurst(actBurst),
    .actDir(actDir), .cmd(cmd), .holdReq(holdReq),
    .addrEnable(addrEnable), .addrStrobe(addrStrobe), .xferOn(xferOn),
    .memRdOn(memRdOn), .memWrOn(memWrOn), .endOfProc(endOfProc)
  );

  for (genvar g = 0; g < NumCh; g++) begin : g_ack
    assign dmaAck[g] = ~((xferOn && (cmd.chan == ChanW'(g))) ^ ackHigh);
  end

  assign busAddr = addrEnable ? actAddr : '0;
  assign memRdN  = !memRdOn;
  assign ioWrN   = !memRdOn;
  assign memWrN  = !memWrOn;
  assign ioRdN   = !memWrOn;
endmodule

// File: rtl/dma4_ctrl_chk.sv
`timescale 1ns/1ps
module dma4_ctrl_chk #(
  parameter int DataW = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               holdReq,
  input logic               holdAck,
  input logic               busReady,
  input logic               addrEnable,
  input logic               addrStrobe,
  input logic [2*DataW-1:0] busAddr,
  input logic               memRdN,
  input logic               memWrN,
  input logic               ioRdN,
  input logic               ioWrN,
  input logic               endOfProc
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstN |=> (!holdReq && !addrEnable && !endOfProc));

  p_grant_first_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(addrEnable) |-> $past(holdAck));

  p_strobe_in_window_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!memRdN || !memWrN) |-> (addrEnable && holdReq));

  p_strobe_pairs_r4: assert property (@(posedge clk) disable iff (!rstN)
    (memRdN == ioWrN) && (memWrN == ioRdN) && (memRdN || memWrN));

  p_wait_holds_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!busReady && (!memRdN || !memWrN)) |=>
      ((!memRdN || !memWrN) && $stable(busAddr)));

  p_strobe_addr_phase_r8: assert property (@(posedge clk) disable iff (!rstN)
    addrStrobe |-> (addrEnable && memRdN && memWrN));

  p_eop_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    endOfProc |=> !endOfProc);
endmodule

bind dma4_ctrl dma4_ctrl_chk #(.DataW(DataW)) u_chk (
  .clk(clk), .rstN(rstN), .holdReq(holdReq), .holdAck(holdAck),
  .busReady(busReady), .addrEnable(addrEnable), .addrStrobe(addrStrobe),
  .busAddr(busAddr), .memRdN(memRdN), .memWrN(memWrN),
  .ioRdN(ioRdN), .ioWrN(ioWrN), .endOfProc(endOfProc)
);

// File: tb/dma4_ctrl_test.sv
`timescale 1ns/1ps
module dma4_ctrl_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuWr = 1'b0, cpuRd = 1'b0;
  logic [3:0]  cpuAddr = '0;
  logic [7:0]  cpuWrData = '0;
  logic [7:0]  cpuRdData;
  logic [3:0]  dmaReq = '0;
  logic [3:0]  dmaAck;
  logic        holdReq;
  logic        holdAck = 1'b0;
  logic        busReady = 1'b1;
  logic        addrEnable, addrStrobe;
  logic [15:0] busAddr;
  logic        memRdN, memWrN, ioRdN, ioWrN, endOfProc;

  always #2 clk = ~clk;

  dma4_ctrl uut (
    .clk(clk), .rstN(rstN), .cpuWr(cpuWr), .cpuRd(cpuRd), .cpuAddr(cpuAddr),
    .cpuWrData(cpuWrData), .cpuRdData(cpuRdData), .dmaReq(dmaReq),
    .dmaAck(dmaAck), .holdReq(holdReq), .holdAck(holdAck),
    .busReady(busReady), .addrEnable(addrEnable), .addrStrobe(addrStrobe),
    .busAddr(busAddr), .memRdN(memRdN), .memWrN(memWrN), .ioRdN(ioRdN),
    .ioWrN(ioWrN), .endOfProc(endOfProc)
  );

  int nCmp = 0, nBad = 0;
  int adstbCnt = 0, hrqFalls = 0, eopCnt = 0;
  logic hrqPrev = 1'b0;
  logic grantEn = 1'b1;
  logic ackHighTb = 1'b0;
  logic done = 1'b0;
  logic [18:0] expQ [$];
  logic [3:0]  ackOn;
  logic [1:0]  gotCh;
  logic [18:0] gotItem, expItem;
  logic [7:0]  rdv;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // CPU model and scoreboard monitor
  always @(negedge clk) begin
    holdAck <= grantEn && holdReq;
    if (rstN) begin
      if (addrStrobe) adstbCnt++;
      if (endOfProc) eopCnt++;
      if (hrqPrev && !holdReq) hrqFalls++;
      hrqPrev = holdReq;
      if (busReady && (!memRdN || !memWrN)) begin
        ackOn = ackHighTb ? dmaAck : ~dmaAck;
        gotCh = ackOn[0] ? 2'd0 : ackOn[1] ? 2'd1 : ackOn[2] ? 2'd2 : 2'd3;
        check("R3 one ack active", 32'($countones(ackOn)), 32'd1);
        check("R4 strobe pairing", {memRdN, ioWrN, memWrN, ioRdN},
              memRdN ? 4'b1100 : 4'b0011);
        gotItem = {!memRdN, gotCh, busAddr};
        if (expQ.size() == 0) begin
          check("R3 unexpected transfer", gotItem, 19'h7FFFF);
        end else begin
          expItem = expQ.pop_front();
          check("R3 R4 R6 transfer dir/chan/addr", gotItem, expItem);
        end
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    cpuAddr = a; cpuWrData = d; cpuWr = 1'b1;
    @(posedge clk); #1;
    cpuWr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(posedge clk); #1;
    cpuAddr = a; cpuRd = 1'b1;
    #1 d = cpuRdData;
    @(posedge clk); #1;
    cpuRd = 1'b0;
  endtask

  task automatic progChan(input int ch, input logic [15:0] a, input logic [15:0] n);
    wr(4'd12, 8'h00);
    wr(4'(2*ch), a[7:0]);   wr(4'(2*ch), a[15:8]);
    wr(4'(2*ch+1), n[7:0]); wr(4'(2*ch+1), n[15:8]);
  endtask

  task automatic pushRun(input int ch, input logic dir, input logic [15:0] a, input int n);
    for (int i = 0; i < n; i++) expQ.push_back({dir, 2'(ch), 16'(a + 16'(i))});
  endtask

  task automatic clearCounts();
    @(posedge clk); #1;
    adstbCnt = 0; hrqFalls = 0; eopCnt = 0;
  endtask

  task automatic waitDrain(input string tag);
    for (int i = 0; i < 3000; i++) begin
      @(posedge clk);
      if (expQ.size() == 0 && !holdReq && !addrEnable) break;
    end
    repeat (4) @(posedge clk);
    #1;
    check(tag, 32'(expQ.size()), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nCmp++; nBad++;
      $display("FAIL watchdog R5 act=hung exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rstN = 1'b1;
    // R1 reset state
    check("R1 holdReq", holdReq, 1'b0);
    check("R1 addrEnable", addrEnable, 1'b0);
    check("R1 acks inactive", dmaAck, 4'hF);
    check("R1 strobes", {memRdN, memWrN, ioRdN, ioWrN}, 4'hF);
    check("R1 eop/addr", {endOfProc, busAddr}, 17'h0);
    rd(4'd9, rdv);
    check("R1 status", rdv, 8'h00);

    // R1 masks set at reset: request alone does nothing
    progChan(0, 16'h12FE, 16'd3);
    wr(4'd11, 8'h00);
    @(posedge clk); #1 dmaReq = 4'b0001;
    repeat (8) @(posedge clk);
    #1 check("R1 masked no hold", holdReq, 1'b0);
    rd(4'd9, rdv);
    check("R11 status request nibble", rdv, 8'h10);

    // R2 no bus drive before grant
    grantEn = 1'b0;
    wr(4'd10, 8'h00);
    repeat (6) @(posedge clk);
    #1;
    check("R2 hold raised", holdReq, 1'b1);
    check("R2 no aen before grant", addrEnable, 1'b0);
    check("R2 no ack before grant", dmaAck, 4'hF);
    pushRun(0, 1'b0, 16'h12FE, 3);
    clearCounts();
    grantEn = 1'b1;
    waitDrain("R5 single drained");
    check("R8 adstb per grant", adstbCnt, 3);
    check("R5 single hold drops", hrqFalls, 3);
    check("R9 eop once", eopCnt, 1);
    rd(4'd9, rdv);
    check("R9 tc status", rdv, 8'h11);
    rd(4'd9, rdv);
    check("R12 status cleared", rdv, 8'h10);
    repeat (8) @(posedge clk);
    #1 check("R9 auto-masked", holdReq, 1'b0);
    wr(4'd12, 8'h00);
    rd(4'd0, rdv); check("R3 R11 addr low", rdv, 8'h01);
    rd(4'd0, rdv); check("R3 R11 addr high", rdv, 8'h13);
    rd(4'd1, rdv); check("R3 count low", rdv, 8'h00);
    rd(4'd1, rdv); check("R3 count high", rdv, 8'h00);
    @(posedge clk); #1 dmaReq = 4'b0000;

    // R5 R8 burst read across a low-byte carry, software request
    progChan(2, 16'h00FE, 16'd4);
    wr(4'd11, 8'h0E);
    wr(4'd10, 8'h02);
    pushRun(2, 1'b1, 16'h00FE, 4);
    clearCounts();
    wr(4'd14, 8'h06);
    waitDrain("R5 burst drained");
    check("R8 adstb grant+carry", adstbCnt, 2);
    check("R5 burst holds bus", hrqFalls, 1);
    check("R9 burst eop", eopCnt, 1);
    rd(4'd9, rdv);
    check("R9 tc ch2", rdv, 8'h04);
    wr(4'd12, 8'h00);
    rd(4'd4, rdv); check("R3 ch2 addr low", rdv, 8'h02);
    rd(4'd4, rdv); check("R3 ch2 addr high", rdv, 8'h01);

    // R6 fixed priority, single mode
    progChan(1, 16'h2000, 16'd2);
    progChan(3, 16'h3000, 16'd2);
    wr(4'd11, 8'h01);
    wr(4'd11, 8'h03);
    wr(4'd15, 8'h00);
    pushRun(1, 1'b0, 16'h2000, 2);
    pushRun(3, 1'b0, 16'h3000, 2);
    clearCounts();
    @(posedge clk); #1 dmaReq = 4'b1010;
    waitDrain("R6 priority drained");
    check("R6 two terminal counts", eopCnt, 2);
    @(posedge clk); #1 dmaReq = 4'b0000;

    // R7 wait states
    progChan(0, 16'h4000, 16'd1);
    wr(4'd11, 8'h00);
    wr(4'd10, 8'h00);
    pushRun(0, 1'b0, 16'h4000, 1);
    @(posedge clk); #1 busReady = 1'b0; dmaReq = 4'b0001;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (!memWrN) break;
    end
    check("R7 strobe reached", memWrN, 1'b0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R7 strobes held", {memWrN, ioRdN}, 2'b00);
      check("R7 address held", busAddr, 16'h4000);
      check("R7 ack held", dmaAck, 4'b1110);
    end
    @(posedge clk); #1 busReady = 1'b1;
    waitDrain("R7 drained");
    @(posedge clk); #1 dmaReq = 4'b0000;

    // R10 polarity flip
    @(posedge clk); #1 dmaReq = 4'hF;
    wr(4'd8, 8'h03);
    ackHighTb = 1'b1;
    check("R10 ack inactive low", dmaAck, 4'h0);
    progChan(3, 16'h5555, 16'd2);
    wr(4'd11, 8'h0B);
    wr(4'd10, 8'h03);
    pushRun(3, 1'b0, 16'h5555, 2);
    clearCounts();
    @(posedge clk); #1 dmaReq = 4'b0111;
    waitDrain("R10 drained");
    check("R10 R5 burst hold", hrqFalls, 1);
    @(posedge clk); #1 dmaReq = 4'hF;
    rd(4'd9, rdv);
    check("R9 R12 tc accumulated", rdv, 8'h0B);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule